// File: doc/BRIEF.md
# Linked-Descriptor Packet DMA Engine

This block moves packets between a shared word-addressed memory and two byte streams, one outgoing and one incoming. Software builds rings of descriptors in memory. Each descriptor points to a buffer, carries an ownership flag and a length, and names the descriptor that follows it. Software then hands the engine a starting descriptor address and an enable bit for each direction through a small register bus.

The transmit walker takes each descriptor that holds a packet and plays the buffer out as bytes. It then marks the descriptor free again and follows the link. It halts by itself when it meets a descriptor that holds no packet. The receive walker waits for a free descriptor and packs incoming bytes into its buffer. It then records the length, hands the descriptor back to software and moves on. When it meets a descriptor that software has not yet drained, it holds the incoming stream off. Both directions share one memory port. The receive side has priority for that port.

Top module: `desc_dma_engine`

## Requirements
- R1: A descriptor at word address P occupies three words. P holds the buffer word address, P+1 the configuration word and P+2 the address of the next descriptor. In the configuration word, bit 31 set means "empty" (owned by the engine for receive, nothing to send for transmit) and bits 11:0 hold the byte count.
- R2: With transmit enabled, a descriptor whose bit 31 is clear produces exactly its byte count on tx_data. Bytes are taken from consecutive buffer words, least significant byte first, and tx_last marks the final byte.
- R3: After its last byte is sent, a transmit descriptor's configuration word is rewritten with bit 31 set and the byte count unchanged. The engine then continues at the descriptor named by word P+2.
- R4: When transmit fetches a descriptor whose bit 31 is set, it stops, clears its enable and leaves its pointer on that descriptor. Writing the enable again resumes from there.
- R5: Receive fills only a descriptor whose bit 31 is set. It packs bytes least significant first into consecutive buffer words, with unused upper bytes of the last word zero. It then writes the frame length into bits 11:0 with bit 31 clear and follows the link.
- R6: When receive meets a descriptor with bit 31 clear, it holds rx_ready low and adds one to the overflow field (bits 31:16 of the receive status) once per such stall. It keeps re-reading the descriptor and resumes once software sets bit 31 again.
- R7: The status words (transmit at 0x188, receive at 0x194) hold in bits 15:0 a count that rises by exactly one per completed descriptor. Both read 0 after reset.
- R8: Bit 0 of the control words (transmit 0x180, receive 0x18C) enables that direction. Writing 0 lets a descriptor already in progress complete and starts no new one. Bit 0 reads 1 while the direction is enabled or still busy, and reads 0 once it is idle.
- R9: The pointer words (transmit 0x184, receive 0x190) read back the current descriptor address. A write to a pointer word is ignored while that direction is enabled or busy.
- R10: While tx_valid is high and tx_ready is low, tx_valid, tx_data and tx_last hold their values.
- R11: A transmit descriptor with byte count 0 sends nothing, is still returned with bit 31 set, and still counts as completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_data | output | 8 | Outgoing byte |
| tx_last | output | 1 | Final byte of a packet |
| tx_ready | input | 1 | Sink accepts the byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_last | input | 1 | Final byte of a frame |
| rx_ready | output | 1 | Engine accepts the byte |

## Verification
The hardest situation to reach is a receive stall that ends. The ring has to be driven full by back-to-back frames, and a frame must be pending on the input while the engine polls a descriptor software still owns. Only then can ownership be handed back. The bench fills a two-entry ring, holds rx_valid high against the stall and observes rx_ready. It then sets the empty bit of the blocking descriptor directly in its memory model and checks that the waiting frame lands there and that the overflow field counted only one stall. A transmit stop issued while a byte is held by a stalled sink covers the case of completing the current descriptor and then going idle.

// File: rtl/dma_pkg.sv
// Package: shared constants and state encodings of the descriptor DMA engine.
// Assumes 32-bit memory words and a 9-bit register byte offset.
package dma_pkg;
    localparam int WORD_W    = 32;
    localparam int CNT_W     = 16;
    localparam int LEN_W     = 12;
    localparam int EMPTY_BIT = 31;
    localparam int RA_W      = 9;

    localparam logic [RA_W-1:0] OFS_TX_CTRL = 9'h180;
    localparam logic [RA_W-1:0] OFS_TX_PTR  = 9'h184;
    localparam logic [RA_W-1:0] OFS_TX_STAT = 9'h188;
    localparam logic [RA_W-1:0] OFS_RX_CTRL = 9'h18C;
    localparam logic [RA_W-1:0] OFS_RX_PTR  = 9'h190;
    localparam logic [RA_W-1:0] OFS_RX_STAT = 9'h194;

    typedef enum logic [3:0] {
        T_IDLE, T_RD_CFG, T_CAP_CFG, T_RD_BUF, T_CAP_BUF, T_RD_DAT,
        T_CAP_DAT, T_SEND, T_WR_CFG, T_RD_NXT, T_CAP_NXT
    } tx_st_t;

    typedef enum logic [3:0] {
        R_IDLE, R_RD_CFG, R_CAP_CFG, R_RD_BUF, R_CAP_BUF, R_RECV,
        R_WR_DAT, R_WR_CFG, R_RD_NXT, R_CAP_NXT
    } rx_st_t;
endpackage

// File: rtl/dma_tx_walker.sv
// Transmit walker: follows the descriptor chain, streams each full buffer
// out byte by byte, returns the descriptor as empty, and halts on an empty one.
// Assumes read data arrives the cycle after a granted read.
module dma_tx_walker
    import dma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              ptr_ld_i,
    input  logic [AW-1:0]     ptr_val_i,
    output logic [AW-1:0]     ptr_o,
    output logic              busy_o,
    output logic              halt_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              req_o,
    output logic              we_o,
    output logic [AW-1:0]     addr_o,
    output logic [WORD_W-1:0] wdata_o,
    input  logic              gnt_i,
    input  logic [WORD_W-1:0] rdata_i,
    output logic              tx_valid_o,
    output logic [7:0]        tx_data_o,
    output logic              tx_last_o,
    input  logic              tx_ready_i
);
    tx_st_t             st;
    logic [AW-1:0]      ptr;
    logic [AW-1:0]      baddr;
    logic [LEN_W-1:0]   len;
    logic [LEN_W-1:0]   left;
    logic [WORD_W-1:0]  word;
    logic [1:0]         bidx;
    logic [CNT_W-1:0]   cnt;

    // Sequencer: walks fetch, stream, write-back and link steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= T_IDLE; ptr <= '0; baddr <= '0; len <= '0; left <= '0;
            word <= '0; bidx <= '0; cnt <= '0;
        end else begin
            case (st)
                T_IDLE: begin
                    if (ptr_ld_i) ptr <= ptr_val_i;
                    if (en_i) st <= T_RD_CFG;
                end
                T_RD_CFG:  if (gnt_i) st <= T_CAP_CFG;
                T_CAP_CFG: begin
                    if (rdata_i[EMPTY_BIT]) st <= T_IDLE;
                    else begin
                        len  <= rdata_i[LEN_W-1:0];
                        left <= rdata_i[LEN_W-1:0];
                        st   <= T_RD_BUF;
                    end
                end
                T_RD_BUF:  if (gnt_i) st <= T_CAP_BUF;
                T_CAP_BUF: begin
                    baddr <= rdata_i[AW-1:0];
                    bidx  <= '0;
                    st    <= (left == '0) ? T_WR_CFG : T_RD_DAT;
                end
                T_RD_DAT:  if (gnt_i) st <= T_CAP_DAT;
                T_CAP_DAT: begin
                    word <= rdata_i;
                    st   <= T_SEND;
                end
                T_SEND: begin
                    if (tx_ready_i) begin
                        left <= left - 1'b1;
                        bidx <= bidx + 1'b1;
                        if (left == LEN_W'(1)) st <= T_WR_CFG;
                        else if (bidx == 2'd3) begin
                            baddr <= baddr + AW'(1);
                            st    <= T_RD_DAT;
                        end
                    end
                end
                T_WR_CFG:  if (gnt_i) st <= T_RD_NXT;
                T_RD_NXT:  if (gnt_i) st <= T_CAP_NXT;
                T_CAP_NXT: begin
                    ptr <= rdata_i[AW-1:0];
                    cnt <= cnt + 1'b1;
                    st  <= en_i ? T_RD_CFG : T_IDLE;
                end
                default: st <= T_IDLE;
            endcase
        end
    end

    // Memory request decode for the current step.
    always_comb begin
        req_o   = 1'b0;
        we_o    = 1'b0;
        addr_o  = ptr + AW'(1);
        wdata_o = '0;
        wdata_o[EMPTY_BIT]   = 1'b1;
        wdata_o[LEN_W-1:0]   = len;
        case (st)
            T_RD_CFG: req_o = 1'b1;
            T_RD_BUF: begin req_o = 1'b1; addr_o = ptr; end
            T_RD_DAT: begin req_o = 1'b1; addr_o = baddr; end
            T_WR_CFG: begin req_o = 1'b1; we_o = 1'b1; end
            T_RD_NXT: begin req_o = 1'b1; addr_o = ptr + AW'(2); end
            default: ;
        endcase
    end

    // Stream and status outputs.
    always_comb begin
        tx_valid_o = (st == T_SEND);
        tx_data_o  = word[{bidx, 3'b000} +: 8];
        tx_last_o  = (left == LEN_W'(1));
        busy_o     = (st != T_IDLE);
        halt_o     = (st == T_CAP_CFG) && rdata_i[EMPTY_BIT];
        ptr_o      = ptr;
        cnt_o      = cnt;
    end
endmodule

// File: rtl/dma_rx_walker.sv
// Receive walker: claims empty descriptors, packs incoming bytes into the
// buffer, writes back the length with ownership returned, and stalls with
// one overflow count per episode on a descriptor software still owns.
// Assumes read data arrives the cycle after a granted read.
module dma_rx_walker
    import dma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              ptr_ld_i,
    input  logic [AW-1:0]     ptr_val_i,
    output logic [AW-1:0]     ptr_o,
    output logic              busy_o,
    output logic              stall_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  ovf_o,
    output logic              req_o,
    output logic              we_o,
    output logic [AW-1:0]     addr_o,
    output logic [WORD_W-1:0] wdata_o,
    input  logic              gnt_i,
    input  logic              rd_empty_i,
    input  logic [AW-1:0]     rd_addr_i,
    input  logic              rx_valid_i,
    input  logic [7:0]        rx_data_i,
    input  logic              rx_last_i,
    output logic              rx_ready_o
);
    rx_st_t             st;
    logic [AW-1:0]      ptr;
    logic [AW-1:0]      baddr;
    logic [LEN_W-1:0]   len;
    logic [WORD_W-1:0]  word;
    logic [1:0]         bpos;
    logic               last_seen;
    logic               stalled;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   ovf;

    // Sequencer: ownership check, byte packing, write-back and link steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= R_IDLE; ptr <= '0; baddr <= '0; len <= '0; word <= '0;
            bpos <= '0; last_seen <= 1'b0; stalled <= 1'b0; cnt <= '0; ovf <= '0;
        end else begin
            case (st)
                R_IDLE: begin
                    if (ptr_ld_i) ptr <= ptr_val_i;
                    if (en_i) st <= R_RD_CFG;
                end
                R_RD_CFG:  if (gnt_i) st <= R_CAP_CFG;
                R_CAP_CFG: begin
                    if (rd_empty_i) begin
                        stalled <= 1'b0;
                        st      <= R_RD_BUF;
                    end else begin
                        if (!stalled) ovf <= ovf + 1'b1;
                        stalled <= en_i;
                        st      <= en_i ? R_RD_CFG : R_IDLE;
                    end
                end
                R_RD_BUF:  if (gnt_i) st <= R_CAP_BUF;
                R_CAP_BUF: begin
                    baddr <= rd_addr_i;
                    len   <= '0;
                    bpos  <= '0;
                    word  <= '0;
                    st    <= R_RECV;
                end
                R_RECV: begin
                    if (rx_valid_i) begin
                        word[{bpos, 3'b000} +: 8] <= rx_data_i;
                        len       <= len + 1'b1;
                        bpos      <= bpos + 1'b1;
                        last_seen <= rx_last_i;
                        if (bpos == 2'd3 || rx_last_i) st <= R_WR_DAT;
                    end else if (!en_i && len == '0) begin
                        st <= R_IDLE;
                    end
                end
                R_WR_DAT: begin
                    if (gnt_i) begin
                        baddr <= baddr + AW'(1);
                        word  <= '0;
                        bpos  <= '0;
                        st    <= last_seen ? R_WR_CFG : R_RECV;
                    end
                end
                R_WR_CFG:  if (gnt_i) st <= R_RD_NXT;
                R_RD_NXT:  if (gnt_i) st <= R_CAP_NXT;
                R_CAP_NXT: begin
                    ptr <= rd_addr_i;
                    cnt <= cnt + 1'b1;
                    st  <= en_i ? R_RD_CFG : R_IDLE;
                end
                default: st <= R_IDLE;
            endcase
        end
    end

    // Memory request decode for the current step.
    always_comb begin
        req_o   = 1'b0;
        we_o    = 1'b0;
        addr_o  = ptr + AW'(1);
        wdata_o = '0;
        wdata_o[LEN_W-1:0] = len;
        case (st)
            R_RD_CFG: req_o = 1'b1;
            R_RD_BUF: begin req_o = 1'b1; addr_o = ptr; end
            R_WR_DAT: begin req_o = 1'b1; we_o = 1'b1; addr_o = baddr; wdata_o = word; end
            R_WR_CFG: begin req_o = 1'b1; we_o = 1'b1; end
            R_RD_NXT: begin req_o = 1'b1; addr_o = ptr + AW'(2); end
            default: ;
        endcase
    end

    // Stream and status outputs.
    always_comb begin
        rx_ready_o = (st == R_RECV);
        busy_o     = (st != R_IDLE);
        stall_o    = stalled;
        ptr_o      = ptr;
        cnt_o      = cnt;
        ovf_o      = ovf;
    end
endmodule

// File: rtl/dma_mem_arb.sv
// Memory arbiter: fixed priority, receive before transmit, one access per
// cycle. Assumes the memory accepts every request in the cycle it is made.
module dma_mem_arb
    import dma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              rx_req_i,
    input  logic              rx_we_i,
    input  logic [AW-1:0]     rx_addr_i,
    input  logic [WORD_W-1:0] rx_wdata_i,
    output logic              rx_gnt_o,
    input  logic              tx_req_i,
    input  logic              tx_we_i,
    input  logic [AW-1:0]     tx_addr_i,
    input  logic [WORD_W-1:0] tx_wdata_i,
    output logic              tx_gnt_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o
);
    // Grant and port multiplexing.
    always_comb begin
        rx_gnt_o    = rx_req_i;
        tx_gnt_o    = tx_req_i && !rx_req_i;
        mem_req_o   = rx_req_i || tx_req_i;
        mem_we_o    = rx_req_i ? rx_we_i    : tx_we_i;
        mem_addr_o  = rx_req_i ? rx_addr_i  : tx_addr_i;
        mem_wdata_o = rx_req_i ? rx_wdata_i : tx_wdata_i;
    end
endmodule

// File: rtl/desc_dma_engine.sv
// Top: register bank plus the two walkers and the shared memory arbiter.
// Assumes single-cycle register writes and combinational register reads.
module desc_dma_engine
    import dma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    output logic              rx_ready
);
    logic              tx_en, rx_en;
    logic              tx_busy, rx_busy, tx_halt, rx_stall;
    logic              tx_ld, rx_ld;
    logic [AW-1:0]     tx_ptr, rx_ptr;
    logic [CNT_W-1:0]  tx_cnt, rx_cnt, rx_ovf;
    logic              tx_mem_req, tx_mem_we, tx_gnt;
    logic              rx_mem_req, rx_mem_we, rx_gnt;
    logic [AW-1:0]     tx_mem_addr, rx_mem_addr;
    logic [31:0]       tx_mem_wdata, rx_mem_wdata;

    // Enable flags: software writes, transmit self-clears on halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en <= 1'b0;
            rx_en <= 1'b0;
        end else begin
            if (reg_we && reg_addr == OFS_TX_CTRL) tx_en <= reg_wdata[0];
            else if (tx_halt)                      tx_en <= 1'b0;
            if (reg_we && reg_addr == OFS_RX_CTRL) rx_en <= reg_wdata[0];
        end
    end

    // Pointer loads are only accepted while the direction is fully idle.
    always_comb begin
        tx_ld = reg_we && reg_addr == OFS_TX_PTR && !tx_en && !tx_busy;
        rx_ld = reg_we && reg_addr == OFS_RX_PTR && !rx_en && !rx_busy;
    end

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_TX_CTRL: reg_rdata[0] = tx_en || tx_busy;
            OFS_TX_PTR:  reg_rdata = 32'(tx_ptr);
            OFS_TX_STAT: reg_rdata = {{(32-CNT_W){1'b0}}, tx_cnt};
            OFS_RX_CTRL: reg_rdata[0] = rx_en || rx_busy;
            OFS_RX_PTR:  reg_rdata = 32'(rx_ptr);
            OFS_RX_STAT: reg_rdata = {rx_ovf, rx_cnt};
            default: ;
        endcase
    end

    dma_tx_walker #(.AW(AW)) u_tx (
        .clk(clk), .rst_n(rst_n), .en_i(tx_en), .ptr_ld_i(tx_ld),
        .ptr_val_i(reg_wdata[AW-1:0]), .ptr_o(tx_ptr), .busy_o(tx_busy),
        .halt_o(tx_halt), .cnt_o(tx_cnt), .req_o(tx_mem_req), .we_o(tx_mem_we),
        .addr_o(tx_mem_addr), .wdata_o(tx_mem_wdata), .gnt_i(tx_gnt),
        .rdata_i(mem_rdata), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
        .tx_last_o(tx_last), .tx_ready_i(tx_ready)
    );

    dma_rx_walker #(.AW(AW)) u_rx (
        .clk(clk), .rst_n(rst_n), .en_i(rx_en), .ptr_ld_i(rx_ld),
        .ptr_val_i(reg_wdata[AW-1:0]), .ptr_o(rx_ptr), .busy_o(rx_busy),
        .stall_o(rx_stall), .cnt_o(rx_cnt), .ovf_o(rx_ovf),
        .req_o(rx_mem_req), .we_o(rx_mem_we), .addr_o(rx_mem_addr),
        .wdata_o(rx_mem_wdata), .gnt_i(rx_gnt), .rd_empty_i(mem_rdata[EMPTY_BIT]),
        .rd_addr_i(mem_rdata[AW-1:0]), .rx_valid_i(rx_valid),
        .rx_data_i(rx_data), .rx_last_i(rx_last), .rx_ready_o(rx_ready)
    );

    dma_mem_arb #(.AW(AW)) u_arb (
        .rx_req_i(rx_mem_req), .rx_we_i(rx_mem_we), .rx_addr_i(rx_mem_addr),
        .rx_wdata_i(rx_mem_wdata), .rx_gnt_o(rx_gnt),
        .tx_req_i(tx_mem_req), .tx_we_i(tx_mem_we), .tx_addr_i(tx_mem_addr),
        .tx_wdata_i(tx_mem_wdata), .tx_gnt_o(tx_gnt),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata)
    );
endmodule

// File: rtl/desc_dma_engine_chk.sv
// Checker: temporal properties of the engine, bound into every instance.
// Assumes reset is held for at least two clock edges.
module desc_dma_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [7:0]  tx_data,
    input logic        tx_last,
    input logic        rx_ready,
    input logic        tx_gnt,
    input logic        rx_gnt,
    input logic        tx_mem_we,
    input logic        tx_wr_flag,
    input logic        rx_stall,
    input logic [15:0] tx_cnt,
    input logic [15:0] rx_cnt,
    input logic [15:0] rx_ovf
);
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R10
    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_gnt, rx_gnt})); // R1
    AST_TX_WB_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_gnt && tx_mem_we) |-> tx_wr_flag); // R3
    AST_RX_STALL_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stall |-> !rx_ready); // R6
    AST_RX_OVF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ovf != $past(rx_ovf)) |-> (rx_ovf == 16'($past(rx_ovf) + 16'd1) && $rose(rx_stall))); // R6
    AST_TX_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt != $past(tx_cnt)) |-> (tx_cnt == 16'($past(tx_cnt) + 16'd1))); // R7
    AST_RX_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt != $past(rx_cnt)) |-> (rx_cnt == 16'($past(rx_cnt) + 16'd1))); // R7
endmodule

bind desc_dma_engine desc_dma_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .rx_ready(rx_ready),
    .tx_gnt(tx_gnt), .rx_gnt(rx_gnt), .tx_mem_we(tx_mem_we),
    .tx_wr_flag(tx_mem_wdata[31]), .rx_stall(rx_stall),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .rx_ovf(rx_ovf)
);

// File: tb/desc_dma_engine_tb.sv
module desc_dma_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        tx_valid, tx_last, tx_ready;
    logic [7:0]  tx_data;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;

    int checks = 0;
    int errors = 0;
    int tx_mode = 0;
    int cyc = 0;
    logic [31:0] mem [0:1023];
    logic [7:0]  exp_q[$];
    logic        exp_last[$];

    always #2.5 clk = ~clk;

    desc_dma_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .tx_ready(tx_ready), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready)
    );

    // Memory model: writes and registered reads.
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[9:0]];
        end
    end

    // Per-clock reference comparison of the transmit stream.
    logic       prev_hold = 1'b0;
    logic [7:0] prev_data = '0;
    logic       prev_last = 1'b0;
    always @(negedge clk) begin
        cyc = cyc + 1;
        case (tx_mode)
            0: tx_ready = 1'b1;
            1: tx_ready = (cyc % 3) != 0;
            default: tx_ready = 1'b0;
        endcase
        if (rst_n) begin
            if (prev_hold) begin
                checks++;
                if (!tx_valid || tx_data !== prev_data || tx_last !== prev_last) begin
                    errors++;
                    $display("FAIL R10 hold act=%b/%h/%b exp=1/%h/%b", tx_valid, tx_data, tx_last, prev_data, prev_last);
                end
            end
            if (tx_valid && tx_ready) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R2 unexpected byte act=%h exp=none", tx_data);
                end else begin
                    logic [7:0] eb;
                    logic       el;
                    eb = exp_q.pop_front();
                    el = exp_last.pop_front();
                    if (tx_data !== eb || tx_last !== el) begin
                        errors++;
                        $display("FAIL R2 byte act=%h/%b exp=%h/%b", tx_data, tx_last, eb, el);
                    end
                end
            end
            prev_hold = tx_valid && !tx_ready;
            prev_data = tx_data;
            prev_last = tx_last;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_reg(input logic [8:0] a, input logic [31:0] msk,
                            input logic [31:0] val, input string req);
        logic [31:0] d;
        int n;
        n = 0;
        reg_read(a, d);
        while ((d & msk) != val && n < 5000) begin
            reg_read(a, d);
            n++;
        end
        check(req, d & msk, val);
    endtask

    // Fill a transmit buffer and record the bytes the stream must carry.
    task automatic fill_tx(input int bufa, input int n, input logic [7:0] seed, input bit expect_it);
        for (int w = 0; w < (n + 3) / 4; w++) mem[bufa + w] = '0;
        for (int i = 0; i < n; i++) begin
            mem[bufa + i / 4][8 * (i % 4) +: 8] = seed + 8'(i);
            if (expect_it) begin
                exp_q.push_back(seed + 8'(i));
                exp_last.push_back(i == n - 1);
            end
        end
    endtask

    task automatic send_frame(input int n, input logic [7:0] seed, input bit gaps);
        int i;
        i = 0;
        while (i < n) begin
            @(negedge clk);
            if (gaps && (cyc % 4 == 0)) begin
                rx_valid = 1'b0;
            end else begin
                rx_valid = 1'b1;
                rx_data  = seed + 8'(i);
                rx_last  = (i == n - 1);
                if (rx_ready) i++;
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=hung exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        tx_mode = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        reg_read(9'h180, d); check("R8 tx ctrl reset", d, 0);
        reg_read(9'h188, d); check("R7 tx status reset", d, 0);
        reg_read(9'h194, d); check("R7 rx status reset", d, 0);
        check("R2 tx_valid reset", {31'b0, tx_valid}, 0);

        // Transmit ring: A(0x100) len 5, B(0x103) len 0, C(0x106) len 8 (R1)
        mem[32'h100] = 32'h200; mem[32'h101] = 32'd5; mem[32'h102] = 32'h103;
        mem[32'h103] = 32'h210; mem[32'h104] = 32'd0; mem[32'h105] = 32'h106;
        mem[32'h106] = 32'h220; mem[32'h107] = 32'd8; mem[32'h108] = 32'h100;
        fill_tx(32'h200, 5, 8'h11, 1);
        fill_tx(32'h220, 8, 8'hA0, 1);
        tx_mode = 1;
        reg_write(9'h184, 32'h100);
        reg_write(9'h180, 32'h1);
        wait_reg(9'h180, 32'h1, 32'h0, "R4 tx halts on empty");
        check("R2 all bytes sent", exp_q.size(), 0);
        check("R3 A returned empty", mem[32'h101], 32'h8000_0005);
        check("R11 zero-length returned", mem[32'h104], 32'h8000_0000);
        check("R3 C returned empty", mem[32'h107], 32'h8000_0008);
        reg_read(9'h188, d); check("R7 R11 tx count", d, 3);
        reg_read(9'h184, d); check("R4 ptr stays on empty", d, 32'h100);

        // Re-arm after refilling A (R4)
        mem[32'h101] = 32'd3;
        fill_tx(32'h200, 3, 8'h40, 1);
        tx_mode = 0;
        reg_write(9'h180, 32'h1);
        wait_reg(9'h180, 32'h1, 32'h0, "R4 re-armed then halts");
        check("R4 re-arm bytes", exp_q.size(), 0);
        reg_read(9'h184, d); check("R4 ptr at B", d, 32'h103);
        reg_read(9'h188, d); check("R7 tx count 4", d, 4);

        // Stop while a byte is held (R8, R9)
        mem[32'h104] = 32'd8; fill_tx(32'h210, 8, 8'h50, 1);
        mem[32'h107] = 32'd2; fill_tx(32'h220, 2, 8'h90, 0);
        tx_mode = 2;
        reg_write(9'h180, 32'h1);
        repeat (20) @(negedge clk);
        reg_write(9'h180, 32'h0);
        reg_read(9'h180, d); check("R8 busy after stop", d, 1);
        reg_write(9'h184, 32'h300);
        reg_read(9'h184, d); check("R9 ptr write ignored busy", d, 32'h103);
        tx_mode = 1;
        wait_reg(9'h180, 32'h1, 32'h0, "R8 idle reads 0");
        check("R8 in-flight finished", exp_q.size(), 0);
        reg_read(9'h188, d); check("R8 tx count 5", d, 5);
        reg_read(9'h184, d); check("R8 stopped before C", d, 32'h106);
        check("R8 C untouched", mem[32'h107], 32'h2);
        reg_write(9'h184, 32'h100);
        reg_read(9'h184, d); check("R9 ptr load when idle", d, 32'h100);

        // Receive ring: D0(0x140) buf 0x280, D1(0x143) buf 0x2C0 (R1)
        mem[32'h140] = 32'h280; mem[32'h141] = 32'h8000_0000; mem[32'h142] = 32'h143;
        mem[32'h143] = 32'h2C0; mem[32'h144] = 32'h8000_0000; mem[32'h145] = 32'h140;
        reg_write(9'h190, 32'h140);
        reg_write(9'h18C, 32'h1);
        reg_write(9'h190, 32'h150);
        reg_read(9'h190, d); check("R9 rx ptr write ignored", d, 32'h140);
        send_frame(6, 8'h61, 1);
        wait_reg(9'h194, 32'hFFFF, 1, "R5 rx count 1");
        check("R5 word0", mem[32'h280], 32'h6463_6261);
        check("R5 word1 padded", mem[32'h281], 32'h0000_6665);
        check("R5 D0 cfg", mem[32'h141], 32'h0000_0006);
        send_frame(4, 8'h71, 0);
        wait_reg(9'h194, 32'hFFFF, 2, "R7 rx count 2");
        check("R5 D1 word", mem[32'h2C0], 32'h7473_7271);
        check("R5 D1 cfg", mem[32'h144], 32'h0000_0004);

        // Stall on D0 still owned by software (R6)
        repeat (10) @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'h81; rx_last = 1'b0;
        begin
            int hi;
            hi = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (rx_ready) hi++;
            end
            check("R6 rx_ready held low", hi, 0);
        end
        reg_read(9'h194, d); check("R6 overflow counted once", d[31:16], 1);
        mem[32'h141] = 32'h8000_0000;
        send_frame(3, 8'h81, 0);
        wait_reg(9'h194, 32'hFFFF, 3, "R6 resumed");
        check("R6 frame after resume", mem[32'h280], 32'h0083_8281);
        check("R6 D0 cfg after resume", mem[32'h141], 32'h0000_0003);
        repeat (10) @(negedge clk);
        reg_read(9'h194, d); check("R6 second stall episode", d[31:16], 2);
        reg_write(9'h18C, 32'h0);
        wait_reg(9'h18C, 32'h1, 32'h0, "R8 rx stop from stall");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule